// File: doc/BRIEF.md
# I/O Error Status Capture

This block sits beside the I/O controller of a host-to-PCI bridge and keeps a record of failed bus cycles. When the controller reports a failure, the block stores the PCI command of that cycle, a cause code and the failing address. It also raises a machine-check request toward the processor. Only the first failure is recorded. Any failure that arrives while a record is held only sets a lost flag, so the original record is not overwritten.

Software reads two registers through a small register port: a status word and the failing address. Both flags are write-one-to-clear, so a handler can clear the record by writing back the status value it has just read. The block also decodes which side started the failing cycle, CPU or PCI. For the page-table and invalid-page causes it exposes the page part of the address and marks that field valid.

Top module: `io_err_status`

## Requirements
- R1: After reset, the status word and the address register both read 0, and `mchk_req_o` is low.
- R2: An error event (`err_valid_i` high at a rising edge) while the logged flag (status bit 4) is clear has these effects from the next cycle: bit 4 reads 1, bits 3:0 hold the command, bits 11:8 hold the cause code, and the address register (`reg_addr_i`=1) holds `err_addr_i`.
- R3: An error event while bit 4 is set leaves bits 3:0, bits 11:8 and the address register unchanged, and sets the lost flag (status bit 5). An error event while bit 4 is clear does not set bit 5.
- R4: While an error is logged, status bit 6 reads 1 when the cause code is greater than 3 (the PCI side started the cycle) and 0 when the code is 0 to 3 (the CPU started it).
- R5: Status bit 12 reads 1 only when the logged cause code is 5 or 6. In that case bits 31:13 hold bits 31:13 of the failing address. Otherwise bits 31:13 read 0.
- R6: A write to the status word (`reg_addr_i`=0) with bit 4 set clears bit 4 and all captured fields, including the address register. A write with bit 5 set clears bit 5. Zero bits in the write data have no effect, and writes to the address register have no effect.
- R7: Writing back the status value just read clears the whole record, so both registers then read 0.
- R8: `mchk_req_o` goes high in the cycle after a capture and stays high until bit 4 is cleared.
- R9: When an error event and a clear of the same flag happen in the same cycle, the set wins. A clear of bit 5 during a lost error leaves bit 5 set. A clear of bit 4 during a new error leaves bit 4 set: the old record stays if one was held, and the new error is captured if none was held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_valid_i | input | 1 | Error event from the I/O controller |
| err_cmd_i | input | 4 | PCI command of the failing cycle |
| err_code_i | input | 4 | Cause code (0..7) |
| err_addr_i | input | 32 | Address of the failing cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 = status, 1 = address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| mchk_req_o | output | 1 | Machine-check request |

## Verification
The hardest cases to reach are the same-cycle collisions. In these, a write-one-to-clear and an error event land on the same clock edge, either while a record is held or while the block is empty. Each of them needs a chosen prior state. To reach them, the bench first builds that state with ordinary captures and partial clears. It then drives the error strobe and the register write in one cycle, and reads both registers back afterwards.

// File: rtl/io_err_pkg.sv
package io_err_pkg;
  localparam int unsigned CMD_W  = 4;
  localparam int unsigned CODE_W = 4;

  localparam int unsigned BIT_ERR   = 4;
  localparam int unsigned BIT_LOST  = 5;
  localparam int unsigned BIT_PCI   = 6;
  localparam int unsigned CODE_LSB  = 8;
  localparam int unsigned BIT_PGV   = 12;

  localparam logic [CODE_W-1:0] CODE_PT_RD   = 4'd5;
  localparam logic [CODE_W-1:0] CODE_BAD_PG  = 4'd6;
  localparam logic [CODE_W-1:0] CODE_CPU_MAX = 4'd3;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [CODE_W-1:0] code;
    logic              pci_init;
    logic              page_vld;
  } err_rec_t;
endpackage

// File: rtl/io_err_decode.sv
module io_err_decode
  import io_err_pkg::*;
(
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [CODE_W-1:0] code_i,
  output err_rec_t          rec_o
);
  always_comb begin
    rec_o.cmd      = cmd_i;
    rec_o.code     = code_i;
    rec_o.pci_init = (code_i > CODE_CPU_MAX);
    rec_o.page_vld = (code_i == CODE_PT_RD) || (code_i == CODE_BAD_PG);
  end
endmodule

// File: rtl/io_err_capture.sv
module io_err_capture
  import io_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_valid_i,
  input  err_rec_t          rec_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_err_i,
  input  logic              clr_lost_i,
  output logic              err_o,
  output logic              lost_o,
  output err_rec_t          rec_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic capture, lost_hit, wipe;

  assign capture  = err_valid_i && !err_o;
  assign lost_hit = err_valid_i && err_o;
  // set beats clear: a pending event blocks the wipe
  assign wipe     = clr_err_i && !err_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o <= 1'b0;
    end else if (err_valid_i) begin
      err_o <= 1'b1;
    end else if (clr_err_i) begin
      err_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lost_o <= 1'b0;
    end else if (lost_hit) begin
      lost_o <= 1'b1;
    end else if (clr_lost_i) begin
      lost_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_o  <= '0;
      addr_o <= '0;
    end else if (capture) begin
      rec_o  <= rec_i;
      addr_o <= addr_i;
    end else if (wipe) begin
      rec_o  <= '0;
      addr_o <= '0;
    end
  end
endmodule

// File: rtl/io_err_regif.sv
module io_err_regif
  import io_err_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned STAT_W   = 32,
  parameter int unsigned PAGE_LSB = 13
) (
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  input  logic              err_i,
  input  logic              lost_i,
  input  err_rec_t          rec_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              clr_err_o,
  output logic              clr_lost_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] rdata_o
);
  localparam int unsigned PG_W = STAT_W - PAGE_LSB;

  logic wr_stat;
  logic unused_wdata;

  assign wr_stat      = reg_wr_i && !reg_addr_i;
  assign clr_err_o    = wr_stat && reg_wdata_i[BIT_ERR];
  assign clr_lost_o   = wr_stat && reg_wdata_i[BIT_LOST];
  assign unused_wdata = ^reg_wdata_i;

  logic [PG_W-1:0] page_f;

  generate
    if (ADDR_W >= STAT_W) begin : g_page
      assign page_f = rec_i.page_vld ? addr_i[PAGE_LSB +: PG_W] : '0;
    end else begin : g_page_narrow
      logic [STAT_W-1:0] addr_ext;
      assign addr_ext = {{(STAT_W-ADDR_W){1'b0}}, addr_i};
      assign page_f   = rec_i.page_vld ? addr_ext[PAGE_LSB +: PG_W] : '0;
    end
  endgenerate

  always_comb begin
    stat_o                        = '0;
    stat_o[CMD_W-1:0]             = rec_i.cmd;
    stat_o[BIT_ERR]               = err_i;
    stat_o[BIT_LOST]              = lost_i;
    stat_o[BIT_PCI]               = rec_i.pci_init;
    stat_o[CODE_LSB +: CODE_W]    = rec_i.code;
    stat_o[BIT_PGV]               = rec_i.page_vld;
    stat_o[STAT_W-1:PAGE_LSB]     = page_f;
  end

  generate
    if (ADDR_W >= STAT_W) begin : g_rd
      assign rdata_o = reg_addr_i ? addr_i[STAT_W-1:0] : stat_o;
    end else begin : g_rd_narrow
      assign rdata_o = reg_addr_i ? {{(STAT_W-ADDR_W){1'b0}}, addr_i} : stat_o;
    end
  endgenerate
endmodule

// File: rtl/io_err_status.sv
module io_err_status
  import io_err_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned STAT_W   = 32,
  parameter int unsigned PAGE_LSB = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_valid_i,
  input  logic [3:0]        err_cmd_i,
  input  logic [3:0]        err_code_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [STAT_W-1:0] reg_rdata_o,
  output logic              mchk_req_o
);
  err_rec_t          rec_in, rec_q;
  logic              err_q, lost_q, clr_err, clr_lost;
  logic [ADDR_W-1:0] addr_q;
  logic [STAT_W-1:0] stat_w;

  io_err_decode u_dec (
    .cmd_i  (err_cmd_i),
    .code_i (err_code_i),
    .rec_o  (rec_in)
  );

  io_err_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .err_valid_i(err_valid_i),
    .rec_i      (rec_in),
    .addr_i     (err_addr_i),
    .clr_err_i  (clr_err),
    .clr_lost_i (clr_lost),
    .err_o      (err_q),
    .lost_o     (lost_q),
    .rec_o      (rec_q),
    .addr_o     (addr_q)
  );

  io_err_regif #(
    .ADDR_W  (ADDR_W),
    .STAT_W  (STAT_W),
    .PAGE_LSB(PAGE_LSB)
  ) u_reg (
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .err_i      (err_q),
    .lost_i     (lost_q),
    .rec_i      (rec_q),
    .addr_i     (addr_q),
    .clr_err_o  (clr_err),
    .clr_lost_o (clr_lost),
    .stat_o     (stat_w),
    .rdata_o    (reg_rdata_o)
  );

  assign mchk_req_o = err_q;
endmodule

// File: rtl/io_err_status_chk.sv
module io_err_status_chk #(
  parameter int unsigned STAT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              err_valid_i,
  input logic              reg_wr_i,
  input logic              reg_addr_i,
  input logic [STAT_W-1:0] reg_wdata_i,
  input logic [STAT_W-1:0] stat,
  input logic              mchk_req_o
);
  // R2
  capture_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_i && !stat[4]) |=> stat[4]);

  // R3
  later_err_keeps_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_i && stat[4]) |=> (stat[5] && stat[4] && $stable(stat[11:0] & 12'hF0F)));

  // R4
  initiator_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat[4] |-> (stat[6] == (stat[11:8] > 4'd3)));

  // R5
  page_valid_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat[12] |-> (stat[11:8] == 4'd5 || stat[11:8] == 4'd6));

  // R6
  w1c_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_valid_i && reg_wr_i && !reg_addr_i && reg_wdata_i[4]) |=> (!stat[4] && !mchk_req_o));

  // R8
  mchk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mchk_req_o) |-> $past(err_valid_i));
endmodule

bind io_err_status io_err_status_chk #(.STAT_W(STAT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .err_valid_i(err_valid_i),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .stat       (stat_w),
  .mchk_req_o (mchk_req_o)
);

// File: tb/sim_io_err_status.sv
`timescale 1ns/1ps
module sim_io_err_status;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        err_valid_i = 1'b0;
  logic [3:0]  err_cmd_i = '0;
  logic [3:0]  err_code_i = '0;
  logic [31:0] err_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic        reg_addr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mchk_req_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk_i = ~clk_i;

  io_err_status u0 (.*);

  function automatic logic [31:0] exp_stat(input logic [3:0] cmd, input logic [3:0] code,
                                           input logic [31:0] a, input bit err, input bit lost);
    logic [31:0] s;
    bit pv;
    pv = (code == 4'd5) || (code == 4'd6);
    s = '0;
    if (err) begin
      s[3:0]   = cmd;
      s[4]     = 1'b1;
      s[6]     = (code > 4'd3);
      s[11:8]  = code;
      s[12]    = pv;
      s[31:13] = pv ? a[31:13] : '0;
    end
    s[5] = lost;
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic rd(input bit sel, output logic [31:0] v);
    reg_addr_i = sel; #0.5;
    v = reg_rdata_o;
  endtask

  // drive one cycle of stimulus, then idle
  task automatic cyc(input bit ev, input logic [3:0] cmd, input logic [3:0] code,
                     input logic [31:0] a, input bit wr, input bit sel, input logic [31:0] wd);
    err_valid_i = ev; err_cmd_i = cmd; err_code_i = code; err_addr_i = a;
    reg_wr_i = wr; reg_addr_i = sel; reg_wdata_i = wd;
    tick();
    err_valid_i = 0; reg_wr_i = 0; reg_wdata_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk("R1 status", v, 32'h0);
    rd(1, v); chk("R1 addr", v, 32'h0);
    chk("R1 mchk", {31'h0, mchk_req_o}, 32'h0);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    cyc(1, 4'd7, 4'd2, 32'h1234_5678, 0, 0, 0);
    rd(0, v); chk("R2 R4 status cpu", v, exp_stat(4'd7, 4'd2, 32'h1234_5678, 1, 0));
    rd(1, v); chk("R2 addr", v, 32'h1234_5678);
    chk("R8 mchk high", {31'h0, mchk_req_o}, 32'h1);
    tick();
    chk("R8 mchk held", {31'h0, mchk_req_o}, 32'h1);
  endtask

  task automatic t_lost_and_writeback();
    logic [31:0] v;
    cyc(1, 4'd11, 4'd6, 32'hFFFF_FFFF, 0, 0, 0);
    rd(0, v); chk("R3 record kept lost set", v, exp_stat(4'd7, 4'd2, 32'h1234_5678, 1, 1));
    rd(1, v); chk("R3 addr kept", v, 32'h1234_5678);
    rd(0, v);
    cyc(0, 0, 0, 0, 1, 0, v);
    rd(0, v); chk("R7 status cleared", v, 32'h0);
    rd(1, v); chk("R7 addr cleared", v, 32'h0);
    chk("R8 mchk low", {31'h0, mchk_req_o}, 32'h0);
  endtask

  task automatic t_codes();
    logic [31:0] v;
    cyc(1, 4'd6, 4'd5, 32'hABCD_E123, 0, 0, 0);
    rd(0, v); chk("R5 R4 code5 page", v, exp_stat(4'd6, 4'd5, 32'hABCD_E123, 1, 0));
    chk("R5 code5 field", v[31:12], {32'hABCD_E123 >> 13, 1'b1});
    chk("R3 no lost on first", {31'h0, v[5]}, 32'h0);
    cyc(0, 0, 0, 0, 1, 0, 32'h10);
    cyc(1, 4'd14, 4'd6, 32'h0000_2000, 0, 0, 0);
    rd(0, v); chk("R5 code6 page", v, exp_stat(4'd14, 4'd6, 32'h0000_2000, 1, 0));
    cyc(0, 0, 0, 0, 1, 0, 32'h10);
    cyc(1, 4'd12, 4'd4, 32'hFFFF_E000, 0, 0, 0);
    rd(0, v); chk("R4 R5 code4 pci no page", v, exp_stat(4'd12, 4'd4, 0, 1, 0));
    cyc(0, 0, 0, 0, 1, 0, 32'h10);
    cyc(1, 4'd3, 4'd7, 32'hDEAD_BEEF, 0, 0, 0);
    rd(0, v); chk("R4 R5 code7", v, exp_stat(4'd3, 4'd7, 0, 1, 0));
    cyc(0, 0, 0, 0, 1, 0, 32'h10);
    rd(0, v); chk("R6 clear bit4", v, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    cyc(1, 4'd10, 4'd1, 32'h0000_0C04, 0, 0, 0);
    cyc(1, 4'd2, 4'd3, 32'h1, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 32'hFFFF_FFCF);
    rd(0, v); chk("R6 zero bits ignored", v, exp_stat(4'd10, 4'd1, 0, 1, 1));
    cyc(0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF);
    rd(1, v); chk("R6 addr write ignored", v, 32'h0000_0C04);
    rd(0, v); chk("R6 addr write no status effect", v, exp_stat(4'd10, 4'd1, 0, 1, 1));
    cyc(0, 0, 0, 0, 1, 0, 32'h20);
    rd(0, v); chk("R6 lost cleared only", v, exp_stat(4'd10, 4'd1, 0, 1, 0));
    chk("R8 mchk during lost clear", {31'h0, mchk_req_o}, 32'h1);
    cyc(0, 0, 0, 0, 1, 0, 32'h10);
    rd(0, v); chk("R6 err cleared", v, 32'h0);
    rd(1, v); chk("R6 addr wiped", v, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    cyc(1, 4'd13, 4'd0, 32'h5555_0000, 0, 0, 0);
    cyc(1, 4'd15, 4'd6, 32'h7777_7777, 1, 0, 32'h30);
    rd(0, v); chk("R9 held set wins", v, exp_stat(4'd13, 4'd0, 0, 1, 1));
    rd(1, v); chk("R9 addr kept", v, 32'h5555_0000);
    chk("R9 mchk held", {31'h0, mchk_req_o}, 32'h1);
    cyc(0, 0, 0, 0, 1, 0, 32'h30);
    rd(0, v); chk("R9 cleared", v, 32'h0);
    cyc(1, 4'd1, 4'd5, 32'h8000_6000, 1, 0, 32'h10);
    rd(0, v); chk("R9 empty capture wins", v, exp_stat(4'd1, 4'd5, 32'h8000_6000, 1, 0));
    rd(1, v); chk("R9 new addr", v, 32'h8000_6000);
  endtask

  initial begin
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_capture();
    t_lost_and_writeback();
    t_codes();
    t_w1c();
    t_set_wins();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule